// File: doc/BRIEF.md
# Host Bridge Configuration Register File

This block holds the byte-addressed configuration space of a host bridge. A configuration engine outside the block presents single-byte accesses, each with a function number, a register offset and write data. The block answers reads in the same cycle. It applies a write rule that belongs to each implemented register: a per-bit write mask, write-one-to-clear status bits, or read-only identity bytes.

Two registers have side effects. Writing the SMI control byte can raise a one-cycle system-management interrupt request, but only while the SMI enable byte permits it. Writing either byte of the SMRAM window selection emits a one-cycle reload strobe when the stored value actually changes. An external SMRAM decoder then reloads its mapping from the two window bytes, which the block also drives out.

Only function 0 is implemented. Every other function number reads as all ones and cannot change any state.

Top module: `hbc_cfg_space`

## Requirements
- R1: A read with a function number other than 0 returns 0xFF on `cfg_rdata`, whatever the offset.
- R2: A write with a function number other than 0 changes no register, raises no SMI request and no reload strobe.
- R3: At offset 0x04 (command low) only the bits in mask 0x4B take the written value, and the bits in mask 0xB4 keep their value. The reset value is 0x80. At offset 0x05 only bits 1:0 are writable.
- R4: Offsets 0x06 and 0x07 (status) are write-one-to-clear: each 1 written clears that stored bit, and each 0 leaves it unchanged. `sts_event[7:0]` sets bits of 0x06 and `sts_event[15:8]` sets bits of 0x07. When a set and a clear of the same bit fall in one cycle, the set wins.
- R5: A function-0 write to offset 0x60 with data bit 1 = 1, while stored 0x60 bit 1 = 0 and stored 0x68 bit 0 = 1, makes `smi_pulse` high for exactly the one cycle after the write's clock edge.
- R6: No SMI request is raised when 0x68 bit 0 is 0, when 0x60 bit 1 is already 1, or when the written bit 1 is 0.
- R7: A function-0 write to offset 0x64 or 0x65 whose data differs from the stored byte makes `remap_strobe` high for the one cycle after the write. A write of the same value gives no strobe.
- R8: A function-0 read returns the stored byte in the same cycle, with no wait state. Unimplemented offsets read 0x00 and ignore writes. Offsets 0x00..0x03 read VENDOR_ID low/high then DEVICE_ID low/high and cannot be written. 0x60, 0x64, 0x65 and 0x68 are fully writable.
- R9: After reset every writable register reads 0x00, except 0x04, which reads 0x80. Both pulse outputs are low.
- R10: `smram_lo` and `smram_hi` always equal the stored bytes at offsets 0x64 and 0x65.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the current access |
| cfg_func | input | FUNC_W | Function number of the access |
| cfg_addr | input | ADDR_W | Register offset |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data, combinational from func/offset |
| sts_event | input | 16 | Status set bits (high byte to 0x07, low byte to 0x06) |
| smi_pulse | output | 1 | One-cycle SMI request |
| remap_strobe | output | 1 | One-cycle SMRAM mapping reload strobe |
| smram_lo | output | 8 | Stored byte at 0x64 |
| smram_hi | output | 8 | Stored byte at 0x65 |

## Verification
The bench sweeps every offset under function 0 and under nonzero functions, and compares each result with a byte model built from the write rules. This catches a decoder that leaks writes from other functions, which would corrupt state, or that answers with stored data instead of 0xFF. It drives the SMI arm bit through its edge and enable corners. A design that fires on level instead of the rising edge, or that ignores the enable, shows an extra or missing pulse. It also repeats same-value window writes, where a strobe on every write would show. Status set and clear are forced into the same cycle, and a design that lets the clear win would lose an event bit. Command writes with patterns across both masks expose a swapped or inverted mask.

// File: rtl/hbc_pkg.sv
package hbc_pkg;

   localparam int unsigned BYTE_W = 8;

   typedef enum logic [0:0] {
      KIND_MASK = 1'b0,
      KIND_W1C  = 1'b1
   } cfg_kind_e;

   typedef struct packed {
      logic [7:0] ofs;
      cfg_kind_e  kind;
      logic [7:0] wmask;
      logic [7:0] rst;
      logic       is_id;
      logic [1:0] id_byte;
   } cfg_desc_t;

   localparam logic [7:0] CMD_LO_OFS = 8'h04;
   localparam logic [7:0] STS_LO_OFS = 8'h06;
   localparam logic [7:0] STS_HI_OFS = 8'h07;
   localparam logic [7:0] SMI_OFS    = 8'h60;
   localparam logic [7:0] WIN_LO_OFS = 8'h64;
   localparam logic [7:0] WIN_HI_OFS = 8'h65;
   localparam logic [7:0] SMI_EN_OFS = 8'h68;

   localparam int unsigned SMI_ARM_BIT = 1;
   localparam int unsigned SMI_EN_BIT  = 0;

   localparam int unsigned NUM_CFG = 12;
   localparam int unsigned IDX_SMI = 8;
   localparam int unsigned IDX_WLO = 9;
   localparam int unsigned IDX_WHI = 10;
   localparam int unsigned IDX_EN  = 11;

   function automatic cfg_desc_t cfg_desc(input int unsigned i);
      cfg_desc_t d;
      d = '{ofs: 8'h00, kind: KIND_MASK, wmask: 8'h00, rst: 8'h00, is_id: 1'b0, id_byte: 2'd0};
      case (i)
         0:  begin d.ofs = 8'h00; d.is_id = 1'b1; d.id_byte = 2'd0; end
         1:  begin d.ofs = 8'h01; d.is_id = 1'b1; d.id_byte = 2'd1; end
         2:  begin d.ofs = 8'h02; d.is_id = 1'b1; d.id_byte = 2'd2; end
         3:  begin d.ofs = 8'h03; d.is_id = 1'b1; d.id_byte = 2'd3; end
         4:  begin d.ofs = CMD_LO_OFS; d.wmask = 8'h4B; d.rst = 8'h80; end
         5:  begin d.ofs = 8'h05; d.wmask = 8'h03; end
         6:  begin d.ofs = STS_LO_OFS; d.kind = KIND_W1C; d.wmask = 8'hFF; end
         7:  begin d.ofs = STS_HI_OFS; d.kind = KIND_W1C; d.wmask = 8'hFF; end
         8:  begin d.ofs = SMI_OFS;    d.wmask = 8'hFF; end
         9:  begin d.ofs = WIN_LO_OFS; d.wmask = 8'hFF; end
         10: begin d.ofs = WIN_HI_OFS; d.wmask = 8'hFF; end
         11: begin d.ofs = SMI_EN_OFS; d.wmask = 8'hFF; end
         default: ;
      endcase
      return d;
   endfunction

endpackage

// File: rtl/hbc_byte_reg.sv
module hbc_byte_reg
   import hbc_pkg::*;
#(
   parameter cfg_kind_e  KIND  = KIND_MASK,
   parameter logic [7:0] WMASK = 8'hFF,
   parameter logic [7:0] RST   = 8'h00
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [BYTE_W-1:0] wdata,
   input  logic [BYTE_W-1:0] set_bits,
   output logic [BYTE_W-1:0] q
);

   logic [BYTE_W-1:0] nxt;

   generate
      if (KIND == KIND_W1C) begin : g_w1c
         always_comb begin
            nxt = q;
            if (wr) nxt = q & ~(wdata & WMASK);
            nxt = nxt | set_bits;
         end
      end else begin : g_mask
         always_comb begin
            nxt = q;
            if (wr) nxt = (q & ~WMASK) | (wdata & WMASK);
            nxt = nxt | set_bits;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= RST;
      else        q <= nxt;
   end

endmodule

// File: rtl/hbc_read_mux.sv
module hbc_read_mux
   import hbc_pkg::*;
#(
   parameter int unsigned N = 4
) (
   input  logic              func_ok,
   input  logic [N-1:0]      hit,
   input  logic [BYTE_W-1:0] vals [N],
   output logic [BYTE_W-1:0] rdata
);

   always_comb begin
      rdata = '0;
      for (int k = 0; k < int'(N); k++) begin
         if (hit[k]) rdata = rdata | vals[k];
      end
      if (!func_ok) rdata = '1;
   end

endmodule

// File: rtl/hbc_side_fx.sv
module hbc_side_fx
   import hbc_pkg::*;
#(
   parameter int unsigned ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr0,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BYTE_W-1:0] wdata,
   input  logic              smi_armed,
   input  logic              smi_en,
   input  logic [BYTE_W-1:0] win_lo,
   input  logic [BYTE_W-1:0] win_hi,
   output logic              smi_pulse,
   output logic              remap_strobe
);

   logic smi_req;
   logic remap_req;

   always_comb begin
      smi_req   = wr0 && (addr == ADDR_W'(SMI_OFS)) && wdata[SMI_ARM_BIT]
                  && !smi_armed && smi_en;
      remap_req = wr0 && (((addr == ADDR_W'(WIN_LO_OFS)) && (wdata != win_lo)) ||
                          ((addr == ADDR_W'(WIN_HI_OFS)) && (wdata != win_hi)));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         smi_pulse    <= 1'b0;
         remap_strobe <= 1'b0;
      end else begin
         smi_pulse    <= smi_req;
         remap_strobe <= remap_req;
      end
   end

endmodule

// File: rtl/hbc_cfg_space.sv
module hbc_cfg_space
   import hbc_pkg::*;
#(
   parameter int unsigned FUNC_W    = 3,
   parameter int unsigned ADDR_W    = 8,
   parameter logic [15:0] VENDOR_ID = 16'h1A2B,
   parameter logic [15:0] DEVICE_ID = 16'h3C4D
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [FUNC_W-1:0] cfg_func,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [BYTE_W-1:0] cfg_wdata,
   output logic [BYTE_W-1:0] cfg_rdata,
   input  logic [2*BYTE_W-1:0] sts_event,
   output logic              smi_pulse,
   output logic              remap_strobe,
   output logic [BYTE_W-1:0] smram_lo,
   output logic [BYTE_W-1:0] smram_hi
);

   localparam logic [31:0] ID_WORD = {DEVICE_ID, VENDOR_ID};

   generate
      if (ADDR_W < 8) begin : g_bad_addr
         $error("hbc_cfg_space: ADDR_W must be at least 8");
      end
      if (FUNC_W < 1) begin : g_bad_func
         $error("hbc_cfg_space: FUNC_W must be at least 1");
      end
      for (genvar a = 0; a < NUM_CFG; a++) begin : g_uniq_a
         for (genvar b = a + 1; b < NUM_CFG; b++) begin : g_uniq_b
            localparam cfg_desc_t DA = cfg_desc(a);
            localparam cfg_desc_t DB = cfg_desc(b);
            if (DA.ofs == DB.ofs) begin : g_dup
               $error("hbc_cfg_space: duplicate register offset");
            end
         end
      end
   endgenerate

   logic                func_ok;
   logic                wr0;
   logic [NUM_CFG-1:0]  hit;
   logic [BYTE_W-1:0]   vals [NUM_CFG];

   assign func_ok = (cfg_func == '0);
   assign wr0     = cfg_wr && func_ok;

   generate
      for (genvar i = 0; i < NUM_CFG; i++) begin : g_reg
         localparam cfg_desc_t  D    = cfg_desc(i);
         localparam logic [7:0] RSTV = D.is_id ? ID_WORD[int'(D.id_byte)*8 +: 8] : D.rst;
         logic [BYTE_W-1:0] set_b;

         if (D.ofs == STS_LO_OFS) begin : g_set_lo
            assign set_b = sts_event[BYTE_W-1:0];
         end else if (D.ofs == STS_HI_OFS) begin : g_set_hi
            assign set_b = sts_event[2*BYTE_W-1:BYTE_W];
         end else begin : g_set_none
            assign set_b = '0;
         end

         assign hit[i] = (cfg_addr == ADDR_W'(D.ofs));

         hbc_byte_reg #(
            .KIND  (D.kind),
            .WMASK (D.wmask),
            .RST   (RSTV)
         ) u_byte (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr       (wr0 && hit[i]),
            .wdata    (cfg_wdata),
            .set_bits (set_b),
            .q        (vals[i])
         );
      end
   endgenerate

   hbc_read_mux #(.N(NUM_CFG)) u_rmux (
      .func_ok (func_ok),
      .hit     (hit),
      .vals    (vals),
      .rdata   (cfg_rdata)
   );

   logic smi_armed_b;
   logic smi_en_b;
   logic [BYTE_W-1:0] smi_byte;
   logic [BYTE_W-1:0] en_byte;

   assign smi_byte    = vals[IDX_SMI];
   assign en_byte     = vals[IDX_EN];
   assign smi_armed_b = smi_byte[SMI_ARM_BIT];
   assign smi_en_b    = en_byte[SMI_EN_BIT];

   hbc_side_fx #(.ADDR_W(ADDR_W)) u_fx (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr0          (wr0),
      .addr         (cfg_addr),
      .wdata        (cfg_wdata),
      .smi_armed    (smi_armed_b),
      .smi_en       (smi_en_b),
      .win_lo       (vals[IDX_WLO]),
      .win_hi       (vals[IDX_WHI]),
      .smi_pulse    (smi_pulse),
      .remap_strobe (remap_strobe)
   );

   assign smram_lo = vals[IDX_WLO];
   assign smram_hi = vals[IDX_WHI];

endmodule

// File: rtl/hbc_checker.sv
module hbc_checker
   import hbc_pkg::*;
#(
   parameter int unsigned FUNC_W = 3,
   parameter int unsigned ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_wr,
   input logic [FUNC_W-1:0] cfg_func,
   input logic [ADDR_W-1:0] cfg_addr,
   input logic [BYTE_W-1:0] cfg_wdata,
   input logic [BYTE_W-1:0] cfg_rdata,
   input logic              smi_pulse,
   input logic              remap_strobe,
   input logic [BYTE_W-1:0] smram_lo,
   input logic [BYTE_W-1:0] smram_hi
);

   assert_foreign_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_func != '0) |-> (cfg_rdata == 8'hFF));

   assert_foreign_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && (cfg_func != '0)) |=>
         ($stable(smram_lo) && $stable(smram_hi) && !smi_pulse && !remap_strobe));

   assert_smi_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      smi_pulse |=> !smi_pulse);

   assert_smi_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
      smi_pulse |-> $past(cfg_wr && (cfg_func == '0) &&
                          (cfg_addr == ADDR_W'(SMI_OFS)) && cfg_wdata[SMI_ARM_BIT]));

   assert_remap_changed_R7: assert property (@(posedge clk) disable iff (!rst_n)
      remap_strobe |-> ((smram_lo != $past(smram_lo)) || (smram_hi != $past(smram_hi))));

   assert_remap_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ((smram_lo != $past(smram_lo)) || (smram_hi != $past(smram_hi))) |-> remap_strobe);

endmodule

bind hbc_cfg_space hbc_checker #(.FUNC_W(FUNC_W), .ADDR_W(ADDR_W)) i_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cfg_wr       (cfg_wr),
   .cfg_func     (cfg_func),
   .cfg_addr     (cfg_addr),
   .cfg_wdata    (cfg_wdata),
   .cfg_rdata    (cfg_rdata),
   .smi_pulse    (smi_pulse),
   .remap_strobe (remap_strobe),
   .smram_lo     (smram_lo),
   .smram_hi     (smram_hi)
);

// File: tb/test_hbc_cfg_space.sv
`timescale 1ns/1ps
module test_hbc_cfg_space;

   localparam logic [15:0] VID = 16'h1A2B;
   localparam logic [15:0] DID = 16'h3C4D;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_wr = 1'b0;
   logic [2:0] cfg_func = '0;
   logic [7:0] cfg_addr = '0;
   logic [7:0] cfg_wdata = '0;
   logic [7:0] cfg_rdata;
   logic [15:0] sts_event = '0;
   logic       smi_pulse;
   logic       remap_strobe;
   logic [7:0] smram_lo;
   logic [7:0] smram_hi;

   int total = 0;
   int bad = 0;
   logic [7:0] mdl [256];

   always #5 clk = ~clk;

   hbc_cfg_space #(.FUNC_W(3), .ADDR_W(8), .VENDOR_ID(VID), .DEVICE_ID(DID)) i_hbc_cfg_space (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_func(cfg_func),
      .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .sts_event(sts_event), .smi_pulse(smi_pulse), .remap_strobe(remap_strobe),
      .smram_lo(smram_lo), .smram_hi(smram_hi)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int a = 0; a < 256; a++) mdl[a] = 8'h00;
      mdl[8'h00] = VID[7:0];
      mdl[8'h01] = VID[15:8];
      mdl[8'h02] = DID[7:0];
      mdl[8'h03] = DID[15:8];
      mdl[8'h04] = 8'h80;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      cfg_wr = 1'b0;
      sts_event = '0;
      model_reset();
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      chk(smi_pulse == 1'b0, "R9 smi after reset", int'(smi_pulse), 0);
      chk(remap_strobe == 1'b0, "R9 strobe after reset", int'(remap_strobe), 0);
   endtask

   // write with optional status events in the same cycle
   task automatic wr_ev(input logic [2:0] f, input logic [7:0] a, input logic [7:0] d,
                        input logic [15:0] ev, input string tag);
      bit exp_smi;
      bit exp_rmp;
      exp_smi = 0;
      exp_rmp = 0;
      if (f == 3'd0) begin
         case (a)
            8'h04: mdl[a] = (mdl[a] & 8'hB4) | (d & 8'h4B);
            8'h05: mdl[a] = (mdl[a] & 8'hFC) | (d & 8'h03);
            8'h06, 8'h07: mdl[a] = mdl[a] & ~d;
            8'h60: begin
               exp_smi = d[1] && !mdl[8'h60][1] && mdl[8'h68][0];
               mdl[a] = d;
            end
            8'h64, 8'h65: begin
               exp_rmp = (d != mdl[a]);
               mdl[a] = d;
            end
            8'h68: mdl[a] = d;
            default: ;
         endcase
      end
      mdl[8'h06] = mdl[8'h06] | ev[7:0];
      mdl[8'h07] = mdl[8'h07] | ev[15:8];
      @(negedge clk);
      cfg_func = f;
      cfg_addr = a;
      cfg_wdata = d;
      cfg_wr = 1'b1;
      sts_event = ev;
      @(negedge clk);
      cfg_wr = 1'b0;
      sts_event = '0;
      chk(smi_pulse == exp_smi, {tag, " smi_pulse"}, int'(smi_pulse), int'(exp_smi));
      chk(remap_strobe == exp_rmp, {tag, " remap_strobe"}, int'(remap_strobe), int'(exp_rmp));
      chk(smram_lo == mdl[8'h64], "R10 smram_lo", int'(smram_lo), int'(mdl[8'h64]));
      chk(smram_hi == mdl[8'h65], "R10 smram_hi", int'(smram_hi), int'(mdl[8'h65]));
   endtask

   task automatic wr(input logic [2:0] f, input logic [7:0] a, input logic [7:0] d,
                     input string tag);
      wr_ev(f, a, d, 16'h0000, tag);
   endtask

   task automatic rd(input logic [2:0] f, input logic [7:0] a, input string tag);
      logic [7:0] e;
      @(negedge clk);
      cfg_func = f;
      cfg_addr = a;
      #1;
      e = (f != 3'd0) ? 8'hFF : mdl[a];
      chk(cfg_rdata == e, tag, int'(cfg_rdata), int'(e));
   endtask

   task automatic rd_all(input string tag);
      for (int a = 0; a < 256; a++) rd(3'd0, 8'(a), tag);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      do_reset();
      rd_all("R9 reset value");

      // R1: foreign function reads
      for (int f = 1; f < 8; f++) begin
         for (int a = 0; a < 256; a += ((f == 1) ? 1 : 13)) rd(3'(f), 8'(a), "R1 foreign read");
      end

      // R2: foreign writes change nothing
      for (int f = 1; f < 8; f++) begin
         wr(3'(f), 8'h68, 8'hFF, "R2");
         wr(3'(f), 8'h60, 8'hFF, "R2");
         wr(3'(f), 8'h64, 8'hA5, "R2");
         wr(3'(f), 8'h65, 8'h5A, "R2");
         wr(3'(f), 8'h04, 8'hFF, "R2");
         wr(3'(f), 8'h06, 8'hFF, "R2");
      end
      rd_all("R2 state after foreign writes");

      // R3: command masks
      wr(3'd0, 8'h04, 8'hFF, "R3"); rd(3'd0, 8'h04, "R3 cmd ff");
      wr(3'd0, 8'h04, 8'h00, "R3"); rd(3'd0, 8'h04, "R3 cmd 00");
      wr(3'd0, 8'h04, 8'hB4, "R3"); rd(3'd0, 8'h04, "R3 cmd b4");
      wr(3'd0, 8'h04, 8'h4B, "R3"); rd(3'd0, 8'h04, "R3 cmd 4b");
      wr(3'd0, 8'h05, 8'hFF, "R3"); rd(3'd0, 8'h05, "R3 cmd hi");

      // R4: status set / clear
      wr_ev(3'd1, 8'h00, 8'h00, 16'hA55A, "R4 event");
      rd(3'd0, 8'h06, "R4 sts lo set"); rd(3'd0, 8'h07, "R4 sts hi set");
      wr(3'd0, 8'h07, 8'h0F, "R4"); rd(3'd0, 8'h07, "R4 w1c hi");
      wr(3'd0, 8'h06, 8'h00, "R4"); rd(3'd0, 8'h06, "R4 zero write");
      wr(3'd0, 8'h06, 8'hF0, "R4"); rd(3'd0, 8'h06, "R4 w1c lo");
      wr_ev(3'd0, 8'h06, 8'hFF, 16'h0081, "R4 same cycle");
      rd(3'd0, 8'h06, "R4 set wins");
      wr(3'd0, 8'h06, 8'hFF, "R4"); wr(3'd0, 8'h07, 8'hFF, "R4");
      rd(3'd0, 8'h06, "R4 cleared lo"); rd(3'd0, 8'h07, "R4 cleared hi");

      // R5 / R6: SMI request
      wr(3'd0, 8'h60, 8'h02, "R6 disabled");
      wr(3'd0, 8'h60, 8'h00, "R6");
      wr(3'd0, 8'h68, 8'hFE, "R6");
      wr(3'd0, 8'h60, 8'h02, "R6 bit0 clear");
      wr(3'd0, 8'h60, 8'h00, "R6");
      wr(3'd0, 8'h68, 8'h01, "R5");
      wr(3'd0, 8'h60, 8'hFD, "R6 bit1 low");
      wr(3'd0, 8'h60, 8'h02, "R5 rising");
      @(negedge clk);
      chk(smi_pulse == 1'b0, "R5 pulse one cycle", int'(smi_pulse), 0);
      wr(3'd0, 8'h60, 8'h02, "R6 already set");
      wr(3'd0, 8'h60, 8'h00, "R5");
      wr(3'd0, 8'h60, 8'hFF, "R5 rising again");

      // R7 / R10: remap strobe
      wr(3'd0, 8'h64, 8'h12, "R7 change lo");
      @(negedge clk);
      chk(remap_strobe == 1'b0, "R7 strobe one cycle", int'(remap_strobe), 0);
      wr(3'd0, 8'h64, 8'h12, "R7 same lo");
      wr(3'd0, 8'h65, 8'h07, "R7 change hi");
      wr(3'd0, 8'h65, 8'h07, "R7 same hi");
      wr(3'd0, 8'h65, 8'h00, "R7 back hi");

      // R8: sweep all offsets
      for (int a = 0; a < 256; a++) begin
         wr(3'd0, 8'(a), 8'(a) ^ 8'h5A, "R8 sweep");
         rd(3'd0, 8'(a), "R8 readback");
      end
      for (int a = 0; a < 256; a++) begin
         wr(3'd0, 8'(a), ~(8'(a) ^ 8'h5A), "R8 sweep inv");
      end
      rd_all("R8 final");

      // R9: reset again
      do_reset();
      rd_all("R9 second reset");

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule